// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm

This block is a system timer for a chip whose register bus runs on a fast clock. A 32768 Hz slow clock also arrives. The block brings the slow clock into the bus domain and turns each of its rising edges into a one-cycle tick. All timer state is updated on that tick, so every register lives in a single clock domain.

A prescaler divides the ticks down. Each time it expires, a free-running real-time counter advances by one and wraps at 2^CNT_W. An absolute-match alarm flags the step on which the counter lands on a programmed value. A periodic interval timer flags every P ticks.

The events collect in a status register that is cleared by a read. Two write-only ports set and clear bits of an interrupt mask. A single interrupt line reports any status bit that is both pending and unmasked.

Top module: `stmr_top`

## Requirements
- R1: After reset the registers hold these values: prescale 32768, period 0, alarm 0, status 0, mask 0, counter 0. The irq output is low.
- R2: The counter advances once for every N slow-clock rising edges, where N is the prescale register (address 0). N = 1 means every edge, and N = 0 means 65536 edges. A write to the prescale register restarts the division phase.
- R3: The counter (read at address 7) only ever stays the same or steps by +1. It wraps modulo 2^CNT_W, and every read returns a value the counter actually held.
- R4: Status bit 3 (alarm) sets on the counter step that makes the counter equal to the alarm register (address 2). Writing the current count therefore fires only after a full wrap.
- R5: The period register (address 1) sets a period of P ticks. After a write of P != 0, status bit 0 sets every P slow-clock ticks. P = 0 stops these events.
- R6: Status bit 2 sets on every counter step.
- R7: Reading the status register (address 3) returns bits [3:0] and clears them. An event that arrives in the same cycle as that read stays set.
- R8: A write to address 4 sets the mask bits where the data is 1. A write to address 5 clears the mask bits where the data is 1. Zero bits leave the mask unchanged. The mask reads back at address 6, using the same bit positions as the status register.
- R9: irq is high exactly when (status AND mask) is nonzero.
- R10: Status bit 1 (watchdog overflow) never sets in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| slow_clk | input | 1 | 32768 Hz slow clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus clock runs at least four times as fast as the slow clock, so that each slow edge gives exactly one isolated tick. They also assume that wr_en and rd_en are never high in the same cycle.

The bench drives the slow clock at one sixteenth of the bus rate, with a fixed phase, and issues one bus access at a time. Accesses that depend on the current count are aligned just after a slow edge, so no counter step falls between a read and the write that follows it. A reduced counter width lets a full wrap of the alarm happen in a short run.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
    localparam int NUM_EVT  = 4;
    localparam int EV_PIT   = 0;
    localparam int EV_WDOG  = 1;
    localparam int EV_INC   = 2;
    localparam int EV_ALARM = 3;

    typedef enum logic [2:0] {
        A_PRESC  = 3'd0,
        A_PERIOD = 3'd1,
        A_ALARM  = 3'd2,
        A_STATUS = 3'd3,
        A_IEN    = 3'd4,
        A_IDIS   = 3'd5,
        A_MASK   = 3'd6,
        A_COUNT  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/stmr_tick_sync.sv
module stmr_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.sh = {q.sh[SH_W-2:0], slow_clk};
        tick = q.sh[SYNC_STAGES-1] & ~q.sh[SYNC_STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/stmr_rtc.sv
module stmr_rtc #(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PRE_W-1:0] presc,
    input  logic             load,
    input  logic [PRE_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm_val,
    output logic [CNT_W-1:0] count,
    output logic             inc_evt,
    output logic             alarm_evt
);
    localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRE_RST - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } rtc_t;

    rtc_t d, q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        d         = q;
        inc_evt   = 1'b0;
        nxt       = q.cnt + CNT_W'(1);
        if (load) begin
            d.pre = load_val - PRE_W'(1);
        end else if (tick) begin
            if (q.pre == '0) begin
                inc_evt = 1'b1;
                d.cnt   = nxt;
                d.pre   = presc - PRE_W'(1);
            end else begin
                d.pre = q.pre - PRE_W'(1);
            end
        end
        alarm_evt = inc_evt && (nxt == alarm_val);
        count     = q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pre <= PRE_INIT;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != $past(q.cnt)) |-> (q.cnt == $past(q.cnt) + CNT_W'(1))); // R3
    AST_ALARM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> (q.cnt == $past(alarm_val))); // R4
endmodule

// File: rtl/stmr_pit.sv
module stmr_pit #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic [PER_W-1:0] period,
    output logic             evt
);
    typedef struct packed {
        logic [PER_W-1:0] left;
    } pit_t;

    pit_t d, q;

    always_comb begin
        d   = q;
        evt = 1'b0;
        if (load) begin
            d.left = load_val;
        end else if (tick && period != '0) begin
            if (q.left <= PER_W'(1)) begin
                evt    = 1'b1;
                d.left = period;
            end else begin
                d.left = q.left - PER_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_PIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !evt); // R5
endmodule

// File: rtl/stmr_top.sv
module stmr_top
    import stmr_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int PRE_W       = 16,
    parameter int PER_W       = 16,
    parameter int DATA_W      = 32,
    parameter int PRE_RST     = 32768,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        logic [PRE_W-1:0]   presc;
        logic [PER_W-1:0]   period;
        logic [CNT_W-1:0]   alarm;
        logic [NUM_EVT-1:0] status;
        logic [NUM_EVT-1:0] mask;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t d, q;

    logic               tick;
    logic [CNT_W-1:0]   count;
    logic               inc_evt, alarm_evt, pit_evt;
    logic [NUM_EVT-1:0] evt;
    logic               presc_load, period_load, status_clr;
    logic [DATA_W-1:0]  rd_v;
    reg_addr_e          sel;
    logic               unused_wdata;

    assign unused_wdata = ^wr_data;

    stmr_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .tick(tick)
    );

    stmr_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .presc(q.presc),
        .load(presc_load), .load_val(wr_data[PRE_W-1:0]),
        .alarm_val(q.alarm), .count(count),
        .inc_evt(inc_evt), .alarm_evt(alarm_evt)
    );

    stmr_pit #(.PER_W(PER_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(period_load), .load_val(wr_data[PER_W-1:0]),
        .period(q.period), .evt(pit_evt)
    );

    always_comb begin
        d   = q;
        sel = reg_addr_e'(addr);

        evt            = '0;
        evt[EV_PIT]    = pit_evt;
        evt[EV_INC]    = inc_evt;
        evt[EV_ALARM]  = alarm_evt;

        presc_load  = wr_en && (sel == A_PRESC);
        period_load = wr_en && (sel == A_PERIOD);
        status_clr  = rd_en && (sel == A_STATUS);

        if (wr_en) begin
            case (sel)
                A_PRESC:  d.presc  = wr_data[PRE_W-1:0];
                A_PERIOD: d.period = wr_data[PER_W-1:0];
                A_ALARM:  d.alarm  = wr_data[CNT_W-1:0];
                A_IEN:    d.mask   = q.mask | wr_data[NUM_EVT-1:0];
                A_IDIS:   d.mask   = q.mask & ~wr_data[NUM_EVT-1:0];
                default:  ;
            endcase
        end

        d.status = (status_clr ? '0 : q.status) | evt;

        rd_v = '0;
        case (sel)
            A_PRESC:  rd_v[PRE_W-1:0]   = q.presc;
            A_PERIOD: rd_v[PER_W-1:0]   = q.period;
            A_ALARM:  rd_v[CNT_W-1:0]   = q.alarm;
            A_STATUS: rd_v[NUM_EVT-1:0] = q.status;
            A_MASK:   rd_v[NUM_EVT-1:0] = q.mask;
            A_COUNT:  rd_v[CNT_W-1:0]   = count;
            default:  ;
        endcase
        if (rd_en) d.rdata = rd_v;

        rd_data = q.rdata;
        irq     = |(q.status & q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.presc <= PRE_W'(PRE_RST);
        end else begin
            q <= d;
        end
    end

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && status_clr) |=> q.status[EV_ALARM]); // R7
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !pit_evt && !inc_evt && !alarm_evt) |=> (q.status == '0)); // R7
    AST_WDOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !q.status[EV_WDOG]); // R10
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4) |=>
        ((q.mask & $past(wr_data[NUM_EVT-1:0])) == $past(wr_data[NUM_EVT-1:0]))); // R8
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5) |=> ((q.mask & $past(wr_data[NUM_EVT-1:0])) == '0)); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mask == '0) |-> !irq); // R9
endmodule

// File: tb/stmr_top_bench.sv
module stmr_top_bench;
    localparam int CW    = 10;
    localparam int SDIV  = 16;
    localparam int WRAP  = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    always #5  clk = ~clk;
    always #80 slow_clk = ~slow_clk;

    stmr_top #(.CNT_W(CW)) u_stmr_top (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        logic [31:0] cmpm;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    longint      cyc = 0;
    logic        rd_seen = 1'b0;
    logic [31:0] last_rd;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_seen <= rd_en;
    end

    // monitor: pops one expected item per completed read
    always @(negedge clk) begin
        if (rd_seen && sb.size() > 0) begin
            item_t it;
            it      = sb.pop_front();
            last_rd = rd_data;
            if (it.cmpm != 0) begin
                n_cmp++;
                if ((rd_data & it.cmpm) != (it.exp & it.cmpm)) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h (mask 0x%0h)",
                             it.tag, rd_data, it.exp, it.cmpm);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [2:0] a, input logic [31:0] exp,
                           input logic [31:0] cmpm, input string tag);
        item_t it;
        it.exp = exp; it.cmpm = cmpm; it.tag = tag;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_val(input logic [2:0] a, output logic [31:0] v);
        do_read(a, 32'h0, 32'h0, "");
        v = last_rd;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic align;
        @(posedge slow_clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_irq(output longint t);
        do @(negedge clk); while (!irq);
        t = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] c1, c2, v;
        longint t0, t1, t2;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_read(3'd0, 32768, 32'hFFFF_FFFF, "R1 prescale");
        do_read(3'd1, 0, 32'hFFFF_FFFF, "R1 period");
        do_read(3'd2, 0, 32'hFFFF_FFFF, "R1 alarm");
        do_read(3'd3, 0, 32'hFFFF_FFFF, "R1 status");
        do_read(3'd6, 0, 32'hFFFF_FFFF, "R1 mask");
        do_read(3'd7, 0, 32'hFFFF_FFFF, "R1 count");
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R2 default rate: no step within 20 slow ticks
        repeat (20) @(posedge slow_clk);
        do_read(3'd7, 0, 32'hFFFF_FFFF, "R2 default prescale holds count");

        // R8 mask set / clear
        do_write(3'd4, 32'h9);
        do_read(3'd6, 32'h9, 32'hF, "R8 enable 1001");
        do_write(3'd5, 32'h1);
        do_read(3'd6, 32'h8, 32'hF, "R8 disable bit0");
        do_write(3'd4, 32'h4);
        do_read(3'd6, 32'hC, 32'hF, "R8 enable bit2 keeps bit3");
        do_write(3'd5, 32'h0);
        do_read(3'd6, 32'hC, 32'hF, "R8 zero disable no effect");
        do_write(3'd5, 32'hF);
        do_read(3'd6, 32'h0, 32'hF, "R8 disable all");

        // R6 / R7 increment status and clear on read
        do_write(3'd0, 1);
        repeat (10) @(posedge slow_clk);
        do_write(3'd0, 32768);
        do_read(3'd3, 32'h4, 32'h6, "R6 increment bit set, R10 wdog clear");
        do_read(3'd3, 32'h0, 32'hF, "R7 status cleared by read");

        // R2 prescale 4 and 1
        do_write(3'd0, 4);
        align; read_val(3'd7, c1);
        repeat (40) @(posedge slow_clk);
        read_val(3'd7, c2);
        v = (c2 - c1) & (WRAP - 1);
        chk(v >= 9 && v <= 11, "R2 prescale 4 rate", v, 10);
        do_write(3'd0, 1);
        align; read_val(3'd7, c1);
        repeat (25) @(posedge slow_clk);
        read_val(3'd7, c2);
        v = (c2 - c1) & (WRAP - 1);
        chk(v >= 24 && v <= 26, "R2 prescale 1 rate", v, 25);

        // R4 near alarm
        align; read_val(3'd7, c1);
        do_write(3'd2, (c1 + 5) & (WRAP - 1));
        read_val(3'd3, v);
        do_write(3'd4, 32'h8);
        wait_irq(t0);
        do_read(3'd7, (c1 + 5) & (WRAP - 1), 32'hFFFF_FFFF, "R4 alarm at exact count");
        do_read(3'd3, 32'h8, 32'hA, "R4 alarm status bit, R10");
        chk(irq == 1'b0, "R9 irq drops after read", irq, 0);

        // R4 / R3 write current count: fires only after full wrap
        align; read_val(3'd7, c1);
        do_write(3'd2, c1);
        read_val(3'd3, v);
        t0 = cyc;
        repeat (500) @(posedge slow_clk);
        chk(irq == 1'b0, "R4 no early alarm", irq, 0);
        wait_irq(t1);
        chk((t1 - t0) > WRAP * SDIV - 40 && (t1 - t0) < WRAP * SDIV + 24,
            "R4 alarm after one wrap", t1 - t0, WRAP * SDIV);
        do_read(3'd7, c1, 32'hFFFF_FFFF, "R3 count back after wrap");
        read_val(3'd3, v);
        do_write(3'd5, 32'hF);

        // R5 periodic spacing
        do_write(3'd4, 32'h1);
        foreach (v[i]) begin end
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 3 : (k == 1) ? 7 : 20;
            do_write(3'd1, p);
            read_val(3'd3, v);
            wait_irq(t0); read_val(3'd3, v);
            wait_irq(t1); read_val(3'd3, v);
            wait_irq(t2); read_val(3'd3, v);
            chk((t1 - t0) == p * SDIV, "R5 spacing first", t1 - t0, p * SDIV);
            chk((t2 - t1) == p * SDIV, "R5 spacing second", t2 - t1, p * SDIV);
        end
        do_write(3'd1, 0);
        read_val(3'd3, v);
        repeat (50) @(posedge slow_clk);
        chk(irq == 1'b0, "R5 period zero stops events, R9", irq, 0);
        do_read(3'd3, 32'h0, 32'h3, "R5 no periodic bit, R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule